// File: doc/BRIEF.md
# Serial-bus slave front end for a small register file

This block is the two-wire serial slave that sits in front of a small register file. It takes the raw clock and data lines and synchronises them to the system clock. From them it picks out bus start and stop conditions and the bit clock edges. It checks an identification byte against a fixed prefix and three board-strap inputs. After that it takes a register address. A write carries one data byte, which goes to the register file through a single-cycle strobe. A read comes after a repeated start and returns bytes from an auto-incrementing pointer for as long as the master acknowledges them.

The slave never drives the data line high. It only asserts an active-high pull-down enable, which the pad ring turns into an open-drain driver. A write-permit input lets the slave refuse data bytes. A busy input, held high by the register file while it is occupied, makes the slave deaf to the bus. The register file is combinational from the slave's point of view: it sees the address port and answers on the read-data port.

Top module: `i2c_regport`

## Requirements
- R1: After a synchronous reset the pull-down enable is 0, the write strobe is 0 and the address output is 0.
- R2: The slave drives an acknowledge (data line low in the ninth clock) only for an identification byte whose bits 7..4 are 1010, whose bits 3..1 equal `strap_id[2:0]`, and whose bit 0 is 0 (write) or 1 (read). A mismatching byte is not acknowledged, and nothing further is acknowledged until the next start.
- R3: The byte that follows a write identification byte is acknowledged and appears on `reg_addr` as the register address.
- R4: When `write_ok` is high, the data byte of a write is acknowledged. It is committed by a one-cycle `reg_wr_stb`, with `reg_addr` and `reg_wr_data` valid, on the falling bit-clock edge that follows its least significant bit.
- R5: When `write_ok` is low at the end of the data byte, that byte is neither acknowledged nor committed, and the slave goes idle until a new start.
- R6: After a repeated start and a read identification byte, the slave sends the byte found at the current address, most significant bit first.
- R7: Each byte sent advances the read address by one. Address 8 is followed by address 0; other addresses count up by one.
- R8: A master not-acknowledge ends the read; the data line is left released until the next start.
- R9: While `busy_in` is high, all bus activity, including a start, is ignored. The pull-down enable goes to 0 and no strobe is issued.
- R10: A start seen in the middle of a transfer abandons it and begins reception of a new identification byte.
- R11: A write commits exactly one data byte; further bytes before the stop are neither acknowledged nor committed.
- R12: A stop condition releases the data line and returns the slave to idle, so that later bytes without a start are ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| scl_in | input | 1 | Raw bus clock line |
| sda_in | input | 1 | Raw bus data line (as seen on the wire) |
| sda_drive_low | output | 1 | Pull-down enable for the open-drain data driver |
| strap_id | input | 3 | Board straps that select the identification value |
| write_ok | input | 1 | High permits writes; low refuses data bytes |
| busy_in | input | 1 | High makes the slave ignore the bus |
| reg_addr | output | 8 | Register address / read pointer |
| reg_wr_stb | output | 1 | One-cycle write commit strobe |
| reg_wr_data | output | 8 | Data byte being committed |
| reg_rd_data | input | 8 | Register contents at `reg_addr` |

## Verification
The assertions watch, on every cycle, the properties that are local in time. The strobe is a single pulse and always coincides with an acknowledge. No strobe follows a refused write permit. The line is released a cycle after busy or a stop. The pointer steps by one and wraps from 8 to 0. Identification matching, the exact bit order of read data, the abandoning of a transfer on a mid-byte start and the silence after a stop or a not-acknowledge only show up across whole bus sequences. The bench therefore drives those sequences against a behavioural register model and checks each acknowledge bit, each byte read and each strobe.

// File: rtl/i2c_regport_pkg.sv
package i2c_regport_pkg;

  typedef enum logic [2:0] {
    S_IDLE,
    S_ID,
    S_ADDR,
    S_WDATA,
    S_ACK,
    S_RDATA,
    S_RACK,
    S_HOLD
  } rp_state_e;

  function automatic logic rx_phase(input rp_state_e s);
    return (s == S_ID) || (s == S_ADDR) || (s == S_WDATA);
  endfunction

endpackage

// File: rtl/rp_bit_sync.sv
module rp_bit_sync #(
  parameter int   STAGES  = 2,
  parameter logic RST_VAL = 1'b1
) (
  input  logic clk,
  input  logic rst,
  input  logic d,
  output logic q
);
  logic [STAGES-1:0] chain;

  always_ff @(posedge clk) begin
    if (rst) chain <= {STAGES{RST_VAL}};
    else     chain <= {chain[STAGES-2:0], d};
  end

  assign q = chain[STAGES-1];
endmodule

// File: rtl/rp_line_cond.sv
module rp_line_cond #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst,
  input  logic scl_raw,
  input  logic sda_raw,
  output logic scl_rise,
  output logic scl_fall,
  output logic start_det,
  output logic stop_det,
  output logic sda_lvl
);
  localparam int LINES = 2;  // index 1 = clock line, index 0 = data line

  logic [LINES-1:0] raw, syn, prev;
  assign raw = {scl_raw, sda_raw};

  for (genvar g = 0; g < LINES; g++) begin : g_sync
    rp_bit_sync #(.STAGES(STAGES), .RST_VAL(1'b1)) u_sync (
      .clk(clk), .rst(rst), .d(raw[g]), .q(syn[g])
    );
  end

  always_ff @(posedge clk) begin
    if (rst) prev <= '1;
    else     prev <= syn;
  end

  assign scl_rise  = syn[1] & ~prev[1];
  assign scl_fall  = ~syn[1] & prev[1];
  assign start_det = syn[1] & prev[1] & prev[0] & ~syn[0];
  assign stop_det  = syn[1] & prev[1] & ~prev[0] & syn[0];
  assign sda_lvl   = syn[0];
endmodule

// File: rtl/rp_shift.sv
module rp_shift #(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         rx_en,
  input  logic         rx_bit,
  input  logic         tx_load,
  input  logic [W-2:0] tx_rest,
  input  logic         tx_shift,
  output logic [W-1:0] rx_byte,
  output logic         tx_next
);
  // Only the bits after the first are held; the first goes out at load time.
  logic [W-2:0] tx_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      rx_byte <= '0;
      tx_q    <= '0;
    end else begin
      if (rx_en) rx_byte <= {rx_byte[W-2:0], rx_bit};
      if (tx_load)       tx_q <= tx_rest;
      else if (tx_shift) tx_q <= {tx_q[W-3:0], 1'b0};
    end
  end

  assign tx_next = tx_q[W-2];
endmodule

// File: rtl/rp_read_ptr.sv
module rp_read_ptr #(
  parameter int AW       = 8,
  parameter int LAST_LOC = 8
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          load,
  input  logic [AW-1:0] load_val,
  input  logic          advance,
  output logic [AW-1:0] ptr
);
  localparam logic [AW-1:0] WRAP_AT = AW'(LAST_LOC);

  always_ff @(posedge clk) begin
    if (rst)          ptr <= '0;
    else if (load)    ptr <= load_val;
    else if (advance) ptr <= (ptr == WRAP_AT) ? '0 : AW'(ptr + 1'b1);
  end

  // R7: the last location is followed by location zero
  p_ptr_wrap_r7: assert property (@(posedge clk) disable iff (rst)
    (advance && !load && ptr == WRAP_AT) |=> (ptr == '0));

  // R7: any other location steps by one
  p_ptr_step_r7: assert property (@(posedge clk) disable iff (rst)
    (advance && !load && ptr != WRAP_AT) |=> (ptr == AW'($past(ptr) + 1'b1)));
endmodule

// File: rtl/i2c_regport.sv
module i2c_regport
  import i2c_regport_pkg::*;
#(
  parameter int DATA_W      = 8,
  parameter int STRAP_W     = 3,
  parameter int ID_PREFIX   = 10,
  parameter int LAST_LOC    = 8,
  parameter int SYNC_STAGES = 2
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               scl_in,
  input  logic               sda_in,
  output logic               sda_drive_low,
  input  logic [STRAP_W-1:0] strap_id,
  input  logic               write_ok,
  input  logic               busy_in,
  output logic [DATA_W-1:0]  reg_addr,
  output logic               reg_wr_stb,
  output logic [DATA_W-1:0]  reg_wr_data,
  input  logic [DATA_W-1:0]  reg_rd_data
);
  localparam int PFX_W = DATA_W - STRAP_W - 1;
  localparam int CNT_W = $clog2(DATA_W + 1);
  localparam logic [CNT_W-1:0] CNT_FULL = CNT_W'(DATA_W);

  logic scl_rise, scl_fall, start_det, stop_det, sda_lvl;
  logic [DATA_W-1:0] rx_byte;
  logic tx_next;

  rp_state_e        state, after_ack;
  logic [CNT_W-1:0] bit_cnt;
  logic             sda_low_q, stb_q, m_ack_q;
  logic [DATA_W-1:0] wdata_q;

  rp_line_cond #(.STAGES(SYNC_STAGES)) u_lines (
    .clk(clk), .rst(rst), .scl_raw(scl_in), .sda_raw(sda_in),
    .scl_rise(scl_rise), .scl_fall(scl_fall),
    .start_det(start_det), .stop_det(stop_det), .sda_lvl(sda_lvl)
  );

  logic cnt_full, live_fall, id_ok;
  logic rx_en, tx_load, tx_shift, ptr_load, ptr_adv;

  assign cnt_full  = (bit_cnt == CNT_FULL);
  assign live_fall = scl_fall & ~busy_in;
  assign id_ok     = (rx_byte[DATA_W-1 -: PFX_W] == PFX_W'(ID_PREFIX)) &&
                     (rx_byte[STRAP_W:1] == strap_id);

  assign rx_en    = scl_rise & rx_phase(state);
  assign tx_load  = live_fall & (((state == S_ACK) && (after_ack == S_RDATA)) ||
                                 ((state == S_RACK) && m_ack_q));
  assign tx_shift = live_fall & (state == S_RDATA) & ~cnt_full;
  assign ptr_load = live_fall & (state == S_ADDR) & cnt_full;
  assign ptr_adv  = live_fall & (state == S_RDATA) & cnt_full;

  rp_shift #(.W(DATA_W)) u_shift (
    .clk(clk), .rst(rst),
    .rx_en(rx_en), .rx_bit(sda_lvl),
    .tx_load(tx_load), .tx_rest(reg_rd_data[DATA_W-2:0]), .tx_shift(tx_shift),
    .rx_byte(rx_byte), .tx_next(tx_next)
  );

  rp_read_ptr #(.AW(DATA_W), .LAST_LOC(LAST_LOC)) u_ptr (
    .clk(clk), .rst(rst),
    .load(ptr_load), .load_val(rx_byte), .advance(ptr_adv),
    .ptr(reg_addr)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      state     <= S_IDLE;
      after_ack <= S_IDLE;
      bit_cnt   <= '0;
      sda_low_q <= 1'b0;
      stb_q     <= 1'b0;
      m_ack_q   <= 1'b0;
      wdata_q   <= '0;
    end else begin
      stb_q <= 1'b0;
      if (busy_in) begin
        state     <= S_IDLE;
        sda_low_q <= 1'b0;
      end else if (start_det) begin
        state     <= S_ID;
        bit_cnt   <= '0;
        sda_low_q <= 1'b0;
      end else if (stop_det) begin
        state     <= S_IDLE;
        sda_low_q <= 1'b0;
      end else begin
        case (state)
          S_ID, S_ADDR, S_WDATA: begin
            if (scl_rise) begin
              bit_cnt <= bit_cnt + 1'b1;
            end else if (scl_fall && cnt_full) begin
              bit_cnt <= '0;
              if (state == S_ID) begin
                if (id_ok) begin
                  sda_low_q <= 1'b1;
                  state     <= S_ACK;
                  after_ack <= rx_byte[0] ? S_RDATA : S_ADDR;
                end else begin
                  state <= S_IDLE;
                end
              end else if (state == S_ADDR) begin
                sda_low_q <= 1'b1;
                state     <= S_ACK;
                after_ack <= S_WDATA;
              end else if (write_ok) begin
                sda_low_q <= 1'b1;
                stb_q     <= 1'b1;
                wdata_q   <= rx_byte;
                state     <= S_ACK;
                after_ack <= S_HOLD;
              end else begin
                state <= S_IDLE;
              end
            end
          end
          S_ACK: begin
            if (scl_fall) begin
              state     <= after_ack;
              sda_low_q <= (after_ack == S_RDATA) ? ~reg_rd_data[DATA_W-1] : 1'b0;
            end
          end
          S_RDATA: begin
            if (scl_rise) begin
              bit_cnt <= bit_cnt + 1'b1;
            end else if (scl_fall) begin
              if (cnt_full) begin
                bit_cnt   <= '0;
                sda_low_q <= 1'b0;
                state     <= S_RACK;
              end else begin
                sda_low_q <= ~tx_next;
              end
            end
          end
          S_RACK: begin
            if (scl_rise) begin
              m_ack_q <= ~sda_lvl;
            end else if (scl_fall) begin
              if (m_ack_q) begin
                state     <= S_RDATA;
                sda_low_q <= ~reg_rd_data[DATA_W-1];
              end else begin
                state <= S_HOLD;
              end
            end
          end
          default: ;
        endcase
      end
    end
  end

  assign sda_drive_low = sda_low_q;
  assign reg_wr_stb    = stb_q;
  assign reg_wr_data   = wdata_q;

  // R4: a commit always coincides with the acknowledge of its data byte
  p_stb_acks_r4: assert property (@(posedge clk) disable iff (rst)
    reg_wr_stb |-> sda_drive_low);

  // R11: the commit is a single-cycle pulse
  p_stb_single_r11: assert property (@(posedge clk) disable iff (rst)
    reg_wr_stb |=> !reg_wr_stb);

  // R5: a refused write permit never produces a commit
  p_wp_blocks_r5: assert property (@(posedge clk) disable iff (rst)
    !write_ok |=> !reg_wr_stb);

  // R9: busy releases the line and blocks commits
  p_busy_quiet_r9: assert property (@(posedge clk) disable iff (rst)
    busy_in |=> (!sda_drive_low && !reg_wr_stb));

  // R12: a stop releases the line
  p_stop_release_r12: assert property (@(posedge clk) disable iff (rst)
    stop_det |=> !sda_drive_low);
endmodule

// File: tb/sim_i2c_regport.sv
module sim_i2c_regport;
  localparam int Q = 6;
  localparam logic [2:0] STRAP = 3'b101;

  logic clk = 1'b0;
  logic rst = 1'b1;
  always #10 clk = ~clk;

  logic scl_m = 1'b1, sda_m = 1'b1, write_ok = 1'b1, busy_in = 1'b0;
  logic sda_drive_low, reg_wr_stb;
  logic [7:0] reg_addr, reg_wr_data, reg_rd_data;
  wire sda_bus = sda_m & ~sda_drive_low;

  i2c_regport u0 (
    .clk(clk), .rst(rst), .scl_in(scl_m), .sda_in(sda_bus),
    .sda_drive_low(sda_drive_low), .strap_id(STRAP), .write_ok(write_ok),
    .busy_in(busy_in), .reg_addr(reg_addr), .reg_wr_stb(reg_wr_stb),
    .reg_wr_data(reg_wr_data), .reg_rd_data(reg_rd_data)
  );

  // external register file driven by the block
  logic [7:0] regs [0:8];
  always @(posedge clk) begin
    if (rst) begin
      for (int i = 0; i < 9; i++) regs[i] <= 8'h80 + 8'(i);
    end else if (reg_wr_stb && reg_addr <= 8) begin
      regs[reg_addr[3:0]] <= reg_wr_data;
    end
  end
  assign reg_rd_data = (reg_addr <= 8) ? regs[reg_addr[3:0]] : (reg_addr ^ 8'hA5);

  // behavioural reference
  logic [7:0] exp_regs [0:8];
  logic [15:0] wq [$];
  int compared = 0, mismatched = 0;
  bit busy_low_seen = 0;

  function automatic logic [7:0] exp_rd(input logic [7:0] a);
    return (a <= 8) ? exp_regs[a[3:0]] : (a ^ 8'hA5);
  endfunction

  task automatic check_eq(input string tag, input string what,
                          input logic [15:0] act, input logic [15:0] exp);
    compared++;
    if (act !== exp) begin
      mismatched++;
      $display("FAIL %s: %s got %h expected %h", tag, what, act, exp);
    end
  endtask

  // per-clock comparison of commits against the expected queue
  always @(negedge clk) begin
    if (!rst) begin
      if (busy_in && sda_drive_low) busy_low_seen = 1;
      if (reg_wr_stb) begin
        compared++;
        if (wq.size() == 0) begin
          mismatched++;
          $display("FAIL R5: unexpected commit got %h expected none", {reg_addr, reg_wr_data});
        end else begin
          logic [15:0] e;
          e = wq.pop_front();
          if ({reg_addr, reg_wr_data} !== e) begin
            mismatched++;
            $display("FAIL R4: commit got %h expected %h", {reg_addr, reg_wr_data}, e);
          end
        end
      end
    end
  end

  task automatic tick(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic bus_start();
    sda_m = 1'b1; tick(Q); scl_m = 1'b1; tick(Q);
    sda_m = 1'b0; tick(Q); scl_m = 1'b0; tick(Q);
  endtask

  task automatic bus_stop();
    sda_m = 1'b0; tick(Q); scl_m = 1'b1; tick(Q); sda_m = 1'b1; tick(Q);
  endtask

  task automatic send_byte(input logic [7:0] b, output bit ack);
    for (int i = 7; i >= 0; i--) begin
      sda_m = b[i]; tick(Q); scl_m = 1'b1; tick(2 * Q); scl_m = 1'b0; tick(Q);
    end
    sda_m = 1'b1; tick(Q); scl_m = 1'b1; tick(Q);
    ack = ~sda_bus;
    tick(Q); scl_m = 1'b0; tick(Q);
  endtask

  task automatic recv_byte(output logic [7:0] b, input bit m_ack);
    for (int i = 7; i >= 0; i--) begin
      sda_m = 1'b1; tick(Q); scl_m = 1'b1; tick(Q);
      b[i] = sda_bus;
      tick(Q); scl_m = 1'b0; tick(Q);
    end
    sda_m = ~m_ack; tick(Q); scl_m = 1'b1; tick(2 * Q); scl_m = 1'b0; tick(Q);
    sda_m = 1'b1;
  endtask

  task automatic do_write(input logic [7:0] a, input logic [7:0] d, input bit ok);
    bit ack;
    bus_start();
    send_byte({4'hA, STRAP, 1'b0}, ack); check_eq("R2", "write id ack", 16'(ack), 16'd1);
    send_byte(a, ack);                   check_eq("R3", "address ack", 16'(ack), 16'd1);
    if (ok) begin
      wq.push_back({a, d});
      if (a <= 8) exp_regs[a[3:0]] = d;
    end
    send_byte(d, ack);
    check_eq(ok ? "R4" : "R5", "data ack", 16'(ack), 16'(ok));
    bus_stop();
  endtask

  task automatic do_read(input logic [7:0] a, input int n);
    bit ack;
    logic [7:0] b, p;
    bus_start();
    send_byte({4'hA, STRAP, 1'b0}, ack); check_eq("R2", "write id ack", 16'(ack), 16'd1);
    send_byte(a, ack);                   check_eq("R3", "address ack", 16'(ack), 16'd1);
    bus_start();
    send_byte({4'hA, STRAP, 1'b1}, ack); check_eq("R2", "read id ack", 16'(ack), 16'd1);
    p = a;
    for (int i = 0; i < n; i++) begin
      recv_byte(b, i != n - 1);
      check_eq(i == 0 ? "R6" : "R7", "read byte", 16'(b), 16'(exp_rd(p)));
      p = (p == 8'd8) ? 8'd0 : p + 8'd1;
    end
    recv_byte(b, 1'b0);  // after NACK the slave must stay silent
    check_eq("R8", "line after NACK", 16'(b), 16'hFF);
    bus_stop();
  endtask

  initial begin : main
    bit ack;
    for (int i = 0; i < 9; i++) exp_regs[i] = 8'h80 + 8'(i);
    tick(5);
    rst = 1'b0;
    tick(2);
    // R1: reset state
    check_eq("R1", "pull-down after reset", 16'(sda_drive_low), 16'd0);
    check_eq("R1", "strobe after reset", 16'(reg_wr_stb), 16'd0);
    check_eq("R1", "address after reset", 16'(reg_addr), 16'd0);

    // R4 / R6: basic write then read back
    do_write(8'h02, 8'h3C, 1'b1);
    tick(4);
    check_eq("R3", "address presented", 16'(reg_addr), 16'h02);
    do_read(8'h02, 1);

    // R7: wrap from 8 to 0
    do_write(8'h07, 8'h71, 1'b1);
    do_write(8'h08, 8'hC8, 1'b1);
    do_write(8'h00, 8'h0F, 1'b1);
    do_read(8'h06, 5);
    // R7: addresses beyond 8 count on
    do_read(8'h20, 2);

    // R2: wrong strap, then wrong prefix
    bus_start();
    send_byte({4'hA, STRAP ^ 3'b001, 1'b0}, ack); check_eq("R2", "wrong strap ack", 16'(ack), 16'd0);
    send_byte(8'h01, ack); check_eq("R2", "ignored address ack", 16'(ack), 16'd0);
    send_byte(8'h55, ack); check_eq("R2", "ignored data ack", 16'(ack), 16'd0);
    bus_stop();
    bus_start();
    send_byte({4'hB, STRAP, 1'b0}, ack); check_eq("R2", "wrong prefix ack", 16'(ack), 16'd0);
    bus_stop();

    // R5: write refused
    write_ok = 1'b0;
    do_write(8'h02, 8'hEE, 1'b0);
    write_ok = 1'b1;
    do_read(8'h02, 1);

    // R9: busy blocks everything, including start
    busy_in = 1'b1;
    tick(2);
    bus_start();
    send_byte({4'hA, STRAP, 1'b0}, ack); check_eq("R9", "id ack while busy", 16'(ack), 16'd0);
    send_byte(8'h04, ack);               check_eq("R9", "addr ack while busy", 16'(ack), 16'd0);
    send_byte(8'h99, ack);               check_eq("R9", "data ack while busy", 16'(ack), 16'd0);
    bus_stop();
    bus_start();
    busy_in = 1'b0;
    send_byte({4'hA, STRAP, 1'b0}, ack); check_eq("R9", "start seen during busy", 16'(ack), 16'd0);
    bus_stop();
    check_eq("R9", "line pulled while busy", 16'(busy_low_seen), 16'd0);

    // R10: start mid-transfer restarts identification
    bus_start();
    send_byte({4'hA, STRAP, 1'b0}, ack); check_eq("R2", "write id ack", 16'(ack), 16'd1);
    send_byte(8'h01, ack);               check_eq("R3", "address ack", 16'(ack), 16'd1);
    bus_start();
    send_byte({4'hA, STRAP, 1'b0}, ack); check_eq("R10", "id after restart", 16'(ack), 16'd1);
    send_byte(8'h03, ack);               check_eq("R10", "addr after restart", 16'(ack), 16'd1);
    wq.push_back({8'h03, 8'h5A}); exp_regs[3] = 8'h5A;
    send_byte(8'h5A, ack);               check_eq("R10", "data after restart", 16'(ack), 16'd1);
    bus_stop();
    do_read(8'h03, 1);

    // R11: only one data byte per write
    bus_start();
    send_byte({4'hA, STRAP, 1'b0}, ack); check_eq("R2", "write id ack", 16'(ack), 16'd1);
    send_byte(8'h05, ack);               check_eq("R3", "address ack", 16'(ack), 16'd1);
    wq.push_back({8'h05, 8'h42}); exp_regs[5] = 8'h42;
    send_byte(8'h42, ack);               check_eq("R4", "data ack", 16'(ack), 16'd1);
    send_byte(8'h77, ack);               check_eq("R11", "second data ack", 16'(ack), 16'd0);
    bus_stop();
    do_read(8'h05, 2);

    // R12: after stop, bytes without a start are ignored
    bus_start();
    send_byte({4'hA, STRAP, 1'b0}, ack); check_eq("R2", "write id ack", 16'(ack), 16'd1);
    bus_stop();
    scl_m = 1'b0; tick(Q);
    send_byte(8'h04, ack);               check_eq("R12", "byte after stop", 16'(ack), 16'd0);
    send_byte(8'h11, ack);               check_eq("R12", "second byte after stop", 16'(ack), 16'd0);
    scl_m = 1'b1; tick(Q);
    bus_stop();

    tick(10);
    check_eq("R4", "commits outstanding", 16'(wq.size()), 16'd0);
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
    $finish;
  end

  initial begin : watchdog
    repeat (150000) @(posedge clk);
    mismatched++;
    $display("FAIL R1: watchdog expired got running expected finished");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
    $finish;
  end
endmodule